// File: doc/BRIEF.md
# Serial Receive Buffer with Position-Tied Error Status

This block sits between the bit-level receiver of an asynchronous serial port and the processor bus. Each cycle in which the receiver presents a completed character, the block works out its parity verdict, takes the receiver's framing verdict, and stores both as tags next to the data byte in a small first-in first-out buffer. The processor sees the oldest character on a data output and reads an 8-bit status byte. A data-read strobe removes the oldest entry.

Error flags are tied to buffer position. A parity or framing flag comes up only once the faulty character has become the oldest entry. An overrun is flagged only once the last character accepted before it has become the oldest entry. After an overrun the block takes no more characters until the overrun flag has been raised and software has cleared it. Asserting the stop input, or an inactive carrier (high) while carrier auto-enable is on, empties the buffer and drops all error state at once.

Top module: `rx_status_fifo`

## Requirements
- R1: The status byte is, from bit 7 down: data-available (buffer not empty), overrun, parity error, framing error, receiver enable, carrier-detect level (1 = inactive), transmitter empty (passed through from `tx_empty`), transmit interrupt enable.
- R2: A character that arrives while the buffer has room is stored. Data-available goes to 1 one cycle after a character is stored into an empty buffer, and `rx_data` always shows the oldest stored character, in arrival order.
- R3: A character with a parity or framing error is still stored and still sets data-available.
- R4: A read strobe removes the oldest character in the cycle it is sampled. Data-available drops to 0 when the last character has been read.
- R5: A character that arrives while the buffer holds DEPTH entries and no read is sampled is an overrun and is discarded. The overrun flag rises one cycle after the last character stored before the overrun has become the oldest entry, and not before.
- R6: From an overrun until the overrun flag has been raised and then cleared by software, every arriving character is discarded.
- R7: With parity checking enabled, a character whose data bits XOR the received parity bit differs from the odd-select bit (0 = even, 1 = odd) is tagged. The parity flag rises one cycle after that character becomes the oldest entry. With checking disabled, no character is tagged.
- R8: A character carrying the framing-error input is tagged. The framing flag rises one cycle after that character becomes the oldest entry.
- R9: A pulse on `err_clr` clears the overrun, parity and framing flags together in the next cycle. An entry whose tag has already been reported does not raise its flag again.
- R10: Reset, `io_stop`, or `cd_n` high while `cd_auto` is 1 empties the buffer and clears all three error flags by the next cycle. `cd_n` high with `cd_auto` 0 has no such effect.
- R11: A control write loads receiver enable from bit 3 and transmit interrupt enable from bit 0. Bits 7 to 4 of the written value are ignored. While receiver enable is 0, arriving characters are ignored.
- R12: An arriving character together with a read on a full buffer is stored and is not an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_stop | input | 1 | Stop request: holds the buffer empty and the flags clear |
| rx_valid | input | 1 | A completed character is present this cycle |
| rx_char | input | DW | Data bits of the completed character |
| rx_par_bit | input | 1 | Parity bit as received |
| rx_frame_err | input | 1 | Framing error verdict for the character |
| par_enable | input | 1 | Parity checking on |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| cd_n | input | 1 | Carrier detect, active low |
| cd_auto | input | 1 | Carrier-detect auto-enable |
| tx_empty | input | 1 | Transmit-empty state, shown in the status byte |
| ctrl_we | input | 1 | Write strobe for the status byte |
| ctrl_wdata | input | 8 | Value written to the status byte |
| err_clr | input | 1 | Write-one pulse clearing the error flags |
| data_rd | input | 1 | Read strobe for the data register |
| status | output | 8 | Status byte |
| rx_data | output | DW | Oldest stored character |

## Verification
Directed sequences fill the buffer past its depth and read it back one entry at a time. This tells an overrun flag raised at the moment of the overrun apart from one raised when the last good entry reaches the head, and shows whether discarding continues until software clears the flag. Mixed clean and faulty characters check that a parity or framing flag waits until its own entry is oldest. Both parity senses, and checking turned off, are tried with the same byte. A constrained random phase mixes arrivals and reads, including arrivals paired with reads on a full buffer, against an ordered queue model. Any lost, duplicated or reordered byte, or a full-buffer swap that is wrongly counted as an overrun, shows up as a data mismatch.

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
  parameter int DEPTH = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_stop,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_char,
  input  logic          rx_par_bit,
  input  logic          rx_frame_err,
  input  logic          par_enable,
  input  logic          par_odd,
  input  logic          cd_n,
  input  logic          cd_auto,
  input  logic          tx_empty,
  input  logic          ctrl_we,
  input  logic [7:0]    ctrl_wdata,
  input  logic          err_clr,
  input  logic          data_rd,
  output logic [7:0]    status,
  output logic [DW-1:0] rx_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0]    mem_d [DEPTH];
  logic [DEPTH-1:0] tag_pe, tag_fe, tag_ov;
  logic [AW-1:0]    rp, wp, wp_last;
  logic [CW-1:0]    cnt;
  logic             ovr_f, pe_f, fe_f, ovr_pend, re_q, tie_q;

  logic flush, empty, full, pop, blocked, take, push, overrun, par_bad, latch;

  assign flush   = io_stop | (cd_auto & cd_n);
  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign pop     = data_rd & ~empty;
  assign blocked = ovr_pend | ovr_f;
  assign take    = rx_valid & re_q & ~blocked;
  assign push    = take & (~full | pop);
  assign overrun = take & full & ~pop;
  assign par_bad = par_enable & ((^rx_char ^ rx_par_bit) != par_odd);
  assign latch   = ~empty & ~err_clr;
  assign wp_last = (wp == '0) ? LAST_IDX : wp - 1'b1;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem_d[wp] <= rx_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_pe <= '0;
      tag_fe <= '0;
      tag_ov <= '0;
    end else if (flush) begin
      tag_pe <= '0;
      tag_fe <= '0;
      tag_ov <= '0;
    end else begin
      if (latch) begin
        tag_pe[rp] <= 1'b0;
        tag_fe[rp] <= 1'b0;
        tag_ov[rp] <= 1'b0;
      end
      if (push) begin
        tag_pe[wp] <= par_bad;
        tag_fe[wp] <= rx_frame_err;
        tag_ov[wp] <= 1'b0;
      end
      if (overrun) tag_ov[wp_last] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_f    <= 1'b0;
      pe_f     <= 1'b0;
      fe_f     <= 1'b0;
      ovr_pend <= 1'b0;
    end else if (flush) begin
      ovr_f    <= 1'b0;
      pe_f     <= 1'b0;
      fe_f     <= 1'b0;
      ovr_pend <= 1'b0;
    end else begin
      if (err_clr) begin
        ovr_f <= 1'b0;
        pe_f  <= 1'b0;
        fe_f  <= 1'b0;
      end else if (latch) begin
        pe_f <= pe_f | tag_pe[rp];
        fe_f <= fe_f | tag_fe[rp];
        if (tag_ov[rp]) ovr_f <= 1'b1;
      end
      if (overrun) ovr_pend <= 1'b1;
      else if (latch && tag_ov[rp]) ovr_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_q  <= 1'b0;
      tie_q <= 1'b0;
    end else if (ctrl_we) begin
      re_q  <= ctrl_wdata[3];
      tie_q <= ctrl_wdata[0];
    end
  end

  assign status  = {~empty, ovr_f, pe_f, fe_f, re_q, cd_n, tx_empty, tie_q};
  assign rx_data = mem_d[rp];

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  p_blocked_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && rx_valid) |=> (cnt <= $past(cnt)));

  p_full_swap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_valid && re_q && !blocked && data_rd && !flush)
      |=> (cnt == FULL_CNT && !ovr_pend));

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !ovr_f && !pe_f && !fe_f));

  p_err_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (!ovr_f && !pe_f && !fe_f));

endmodule

// File: tb/test_rx_status_fifo.sv
module test_rx_status_fifo;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_stop = 0, rx_valid = 0, rx_par_bit = 0, rx_frame_err = 0;
  logic par_enable = 0, par_odd = 0, cd_n = 0, cd_auto = 0, tx_empty = 1;
  logic ctrl_we = 0, err_clr = 0, data_rd = 0;
  logic [7:0] rx_char = '0, ctrl_wdata = '0;
  logic [7:0] status, rx_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rx_status_fifo #(.DEPTH(DEPTH), .DW(8)) i_rx_status_fifo (
    .clk(clk), .rst_n(rst_n), .io_stop(io_stop), .rx_valid(rx_valid),
    .rx_char(rx_char), .rx_par_bit(rx_par_bit), .rx_frame_err(rx_frame_err),
    .par_enable(par_enable), .par_odd(par_odd), .cd_n(cd_n), .cd_auto(cd_auto),
    .tx_empty(tx_empty), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .err_clr(err_clr), .data_rd(data_rd), .status(status), .rx_data(rx_data));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] st(input bit rdrf, input bit ov, input bit pe,
                                    input bit fe, input bit re, input bit tie);
    return {rdrf, ov, pe, fe, re, cd_n, tx_empty, tie};
  endfunction

  function automatic bit bad_par(input logic [7:0] d, input bit p, input bit en, input bit odd);
    return en && ((^d ^ p) != odd);
  endfunction

  task automatic push(input logic [7:0] d, input bit p, input bit f);
    rx_valid = 1; rx_char = d; rx_par_bit = p; rx_frame_err = f;
    tick();
    rx_valid = 0; rx_frame_err = 0; rx_par_bit = 0;
  endtask

  task automatic rd();
    data_rd = 1; tick(); data_rd = 0;
  endtask

  task automatic eclr();
    err_clr = 1; tick(); err_clr = 0;
  endtask

  task automatic wctl(input logic [7:0] v);
    ctrl_we = 1; ctrl_wdata = v; tick(); ctrl_we = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    void'($urandom(32'd4711));
    tick(); tick();
    rst_n = 1;
    tick();
    chk("R1 reset status", status, 8'h02);

    wctl(8'hFF);
    chk("R11 write RE/TIE", status, st(0,0,0,0,1,1));
    wctl(8'h00);
    chk("R11 clear RE/TIE", status, st(0,0,0,0,0,0));
    push(8'h77, 0, 0);
    tick();
    chk("R11 RE off ignores char", status, st(0,0,0,0,0,0));
    wctl(8'h08);

    push(8'h5A, 0, 0);
    chk("R2 rdrf set", status, st(1,0,0,0,1,0));
    chk("R2 data", rx_data, 8'h5A);
    push(8'h33, 0, 0);
    wctl(8'hF8);
    chk("R11 ro bits ignored", status, st(1,0,0,0,1,0));
    rd();
    chk("R4 next oldest", rx_data, 8'h33);
    chk("R4 rdrf still set", status[7], 1'b1);
    rd();
    chk("R4 rdrf clear", status, st(0,0,0,0,1,0));

    par_enable = 1; par_odd = 0;
    push(8'h22, 0, 0);
    push(8'h01, 0, 0);
    tick();
    chk("R7 not yet at head", status, st(1,0,0,0,1,0));
    chk("R3 errored stored after clean", rx_data, 8'h22);
    rd();
    tick();
    chk("R7 parity flag at head", status, st(1,0,1,0,1,0));
    chk("R3 errored char data", rx_data, 8'h01);
    eclr();
    chk("R9 pe cleared", status, st(1,0,0,0,1,0));
    tick();
    chk("R9 no re-raise", status, st(1,0,0,0,1,0));
    rd();

    par_odd = 1;
    push(8'h01, 0, 0);
    tick();
    chk("R7 odd ok", status, st(1,0,0,0,1,0));
    rd();
    push(8'h03, 0, 0);
    tick();
    chk("R7 odd mismatch", status, st(1,0,bad_par(8'h03,0,1,1),0,1,0));
    eclr(); rd();
    par_enable = 0;
    push(8'h01, 0, 0);
    tick();
    chk("R7 parity disabled", status, st(1,0,0,0,1,0));
    rd();

    push(8'h44, 0, 1);
    chk("R3 framed char stored", status, st(1,0,0,0,1,0));
    chk("R3 framed data", rx_data, 8'h44);
    tick();
    chk("R8 framing flag", status, st(1,0,0,1,1,0));
    eclr(); rd();
    chk("R9 fe cleared, empty", status, st(0,0,0,0,1,0));

    for (int i = 0; i < 4; i++) push(8'h10 + 8'(i), 0, 0);
    push(8'h14, 0, 0);
    push(8'h15, 0, 0);
    chk("R5 no flag at overrun", status, st(1,0,0,0,1,0));
    chk("R5 head kept", rx_data, 8'h10);
    rd(); rd();
    chk("R5 still no flag", status[6], 1'b0);
    rd();
    chk("R5 last good at head", rx_data, 8'h13);
    chk("R5 flag not yet", status[6], 1'b0);
    tick();
    chk("R5 flag raised", status, st(1,1,0,0,1,0));
    push(8'h16, 0, 0);
    eclr();
    chk("R9 ovr cleared", status, st(1,0,0,0,1,0));
    rd();
    chk("R6 overrun chars discarded", status, st(0,0,0,0,1,0));
    push(8'h17, 0, 0);
    chk("R6 loading resumed", rx_data, 8'h17);
    rd();

    for (int i = 0; i < 4; i++) push(8'h20 + 8'(i), 0, 0);
    data_rd = 1; push(8'h24, 0, 0); data_rd = 0;
    tick();
    chk("R12 no overrun on swap", status, st(1,0,0,0,1,0));
    for (int i = 1; i <= 4; i++) begin
      chk("R12 swap order", rx_data, 8'h20 + 8'(i));
      rd();
    end
    chk("R12 drained", status, st(0,0,0,0,1,0));

    push(8'h55, 0, 1);
    push(8'h66, 0, 0);
    tick();
    io_stop = 1; tick(); io_stop = 0;
    chk("R10 io_stop flush", status, st(0,0,0,0,1,0));
    cd_n = 1;
    push(8'h67, 0, 0);
    chk("R10 carrier ignored w/o auto", status, st(1,0,0,0,1,0));
    cd_auto = 1; tick(); cd_auto = 0;
    chk("R10 carrier auto flush", status, st(0,0,0,0,1,0));
    cd_n = 0;
    push(8'h68, 0, 1);
    tick();
    rst_n = 0; #1;
    chk("R10 reset clears", status, 8'h02);
    tick(); rst_n = 1; tick();
    wctl(8'h08);

    for (int c = 0; c < 400; c++) begin
      bit dp, dpush;
      logic [7:0] d;
      d = 8'($urandom);
      dp = ($urandom % 2 == 0) && (q.size() > 0);
      dpush = ($urandom % 3 != 0) && ((q.size() < DEPTH) || dp);
      data_rd = dp; rx_valid = dpush; rx_char = d;
      tick();
      data_rd = 0; rx_valid = 0;
      if (dp) void'(q.pop_front());
      if (dpush) q.push_back(d);
      chk("R2 random rdrf", {7'd0, status[7]}, {7'd0, q.size() != 0});
      chk("R12 random no ovr", {7'd0, status[6]}, 8'd0);
      if (q.size() != 0) chk("R2 random order", rx_data, q[0]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule